// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Mapper

This block sits between a 16-bit CPU bus and the memories of a cartridge. It turns CPU writes into bank-register updates and CPU reads into physical addresses for an external ROM of up to 512 banks of 16 KiB and an external RAM of up to 16 banks of 8 KiB. A read whose target is outside the fitted memory, outside a mapped window, or in RAM that is missing or switched off returns 0xFF, and the memories never see it. The ROM size, the number of RAM banks and a RAM-present flag are static configuration inputs.

The ROM bank number is nine bits wide and is written through two registers: one holds the low eight bits and the other holds only the ninth. RAM is switched on by writing exactly 0x0A to the enable range, and any other byte there switches it off. The fixed window 0x0000-0x3FFF always shows the start of the ROM. The switchable window 0x4000-0x7FFF shows the selected ROM bank, and bank 0 is legal there. The RAM window 0xA000-0xBFFF shows the selected RAM bank.

An access controller with five states sequences each bus operation. ACC_IDLE means no operation is active. ACC_ROM, ACC_RAM and ACC_FILL each present one read result for one cycle, with the data taken from the ROM, from the RAM, or set to 0xFF. ACC_RAMWR pulses the RAM write strobe for one cycle. Every state leaves on the next clock. An allowed RAM write moves to ACC_RAMWR. A read moves to ACC_ROM, ACC_RAM or ACC_FILL, according to how its address decodes. With no operation, or with an ignored write, the controller moves to ACC_IDLE. A write takes priority over a read in the same cycle.

Top module: `cart_mapper`

## Requirements
- R1: After reset the ROM bank is 1, the RAM bank is 0 and RAM is disabled. A read of 0x4000+x therefore returns ROM byte 0x4000+x, and a RAM-window read returns 0xFF.
- R2: A write to 0x0000-0x1FFF enables RAM when the data byte is exactly 0x0A. Any other byte disables RAM, including 0x1A and 0x8A.
- R3: A write to 0x2000-0x2FFF replaces ROM bank bits 7:0 with the data byte and leaves bank bit 8 unchanged.
- R4: A write to 0x3000-0x3FFF sets ROM bank bit 8 from data bit 0 and leaves bank bits 7:0 unchanged.
- R5: A write to 0x4000-0x5FFF loads the RAM bank from data bits 3:0. Data bits 7:4 are ignored.
- R6: A read of 0x0000-0x3FFF addresses ROM byte number equal to the CPU address.
- R7: A read of 0x4000-0x7FFF addresses ROM byte bank*0x4000 + (address-0x4000). Bank 0 is used as is.
- R8: The ROM holds 2^(code+1) banks for size code 0 to 8. A switchable-window read whose bank is not below that count returns 0xFF.
- R9: A read of 0xA000-0xBFFF addresses RAM byte bank*0x2000 + (address-0xA000). It returns 0xFF when RAM is absent, when RAM is disabled, or when the bank is not below the configured bank count.
- R10: A RAM-window write is performed by a one-cycle RAM write strobe in the next cycle, carrying the same address mapping and the written data. Under the conditions that make R9 return 0xFF, the write is dropped and the RAM is left unchanged.
- R11: Each read returns its result with the valid flag in the cycle after the read request. Reads of 0x8000-0x9FFF and 0xC000-0xFFFF return 0xFF.
- R12: Writes to 0x6000-0x9FFF and 0xC000-0xFFFF change no bank register and no RAM enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU bus address |
| cpu_wr | input | 1 | Write request, one cycle per operation |
| cpu_rd | input | 1 | Read request, one cycle per operation |
| cpu_wdata | input | 8 | Write data |
| rom_size_code | input | 4 | ROM size code: 2^(code+1) banks, code 0 to 8 |
| ram_banks | input | 5 | Number of fitted RAM banks, 0 to 16 |
| ram_present | input | 1 | RAM is fitted |
| rom_addr | output | 23 | Physical ROM byte address |
| rom_rdata | input | 8 | ROM data for rom_addr |
| ram_addr | output | 17 | Physical RAM byte address |
| ram_rdata | input | 8 | RAM data for ram_addr |
| ram_we | output | 1 | RAM write strobe |
| ram_wdata | output | 8 | RAM write data |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read result |

## Verification
The assertions assume that read and write requests never arrive in the same cycle, that each request is held for exactly one cycle, and that the configuration inputs change only while no operation is in flight. The bench drives every operation as a single-cycle pulse set up on the falling edge. It issues one operation at a time and changes the size code, bank count and presence flag only between operations. Random size codes stay within 0 to 8, and random bank counts stay within 0 to 16.

// File: rtl/cart_mapper_pkg.sv
package cart_mapper_pkg;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_ROM,
        ACC_RAM,
        ACC_FILL,
        ACC_RAMWR
    } acc_state_t;

    typedef enum logic [1:0] {
        RC_ROM,
        RC_RAM,
        RC_FILL
    } rd_class_t;

    localparam logic [7:0] FILL_BYTE  = 8'hFF;
    localparam logic [7:0] RAM_EN_KEY = 8'h0A;
    localparam logic [2:0] RAM_WIN_TAG = 3'b101;

endpackage

// File: rtl/mapper_bank_regs.sv
module mapper_bank_regs #(
    parameter int DW         = 8,
    parameter int ROM_BANK_W = 9,
    parameter int RAM_BANK_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [3:0]            reg_sel,
    input  logic [DW-1:0]         wdata,
    output logic [ROM_BANK_W-1:0] rom_bank,
    output logic [RAM_BANK_W-1:0] ram_bank,
    output logic                  ram_en
);
    import cart_mapper_pkg::*;

    localparam int HI_W = ROM_BANK_W - DW;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rom_bank <= ROM_BANK_W'(1);
            ram_bank <= '0;
            ram_en   <= 1'b0;
        end else if (wr_en) begin
            unique case (reg_sel)
                4'h0, 4'h1: ram_en <= (wdata == RAM_EN_KEY);
                4'h2:       rom_bank[DW-1:0] <= wdata;
                4'h3:       rom_bank[ROM_BANK_W-1:DW] <= wdata[HI_W-1:0];
                4'h4, 4'h5: ram_bank <= wdata[RAM_BANK_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mapper_xlate.sv
module mapper_xlate #(
    parameter int ROM_BANK_W = 9,
    parameter int RAM_BANK_W = 4,
    parameter int ROM_WIN_W  = 14,
    parameter int RAM_WIN_W  = 13,
    parameter int SZ_W       = 4,
    parameter int ROM_AW     = ROM_BANK_W + ROM_WIN_W,
    parameter int RAM_AW     = RAM_BANK_W + RAM_WIN_W
) (
    input  logic [15:0]           cpu_addr,
    input  logic [ROM_BANK_W-1:0] rom_bank,
    input  logic [RAM_BANK_W-1:0] ram_bank,
    input  logic                  ram_en,
    input  logic [SZ_W-1:0]       rom_size_code,
    input  logic [RAM_BANK_W:0]   ram_banks,
    input  logic                  ram_present,
    output cart_mapper_pkg::rd_class_t rd_class,
    output logic                  ram_ok,
    output logic [ROM_AW-1:0]     rom_addr_nx,
    output logic [RAM_AW-1:0]     ram_addr_nx
);
    import cart_mapper_pkg::*;

    logic [ROM_BANK_W-1:0] keep_mask;
    logic                  rom_in_range;
    logic                  in_ram_win;

    // bank bit i exists when i <= size code
    for (genvar i = 0; i < ROM_BANK_W; i++) begin : g_mask
        assign keep_mask[i] = (SZ_W'(i) <= rom_size_code);
    end

    assign rom_in_range = ((rom_bank & ~keep_mask) == '0);
    assign in_ram_win   = (cpu_addr[15:13] == RAM_WIN_TAG);
    assign ram_ok       = ram_present && ram_en && ({1'b0, ram_bank} < ram_banks);
    assign ram_addr_nx  = {ram_bank, cpu_addr[RAM_WIN_W-1:0]};

    always_comb begin
        rom_addr_nx = {ROM_BANK_W'(0), cpu_addr[ROM_WIN_W-1:0]};
        rd_class    = RC_FILL;
        if (cpu_addr[15:14] == 2'b00) begin
            rd_class = RC_ROM;
        end else if (cpu_addr[15:14] == 2'b01) begin
            rom_addr_nx = {rom_bank, cpu_addr[ROM_WIN_W-1:0]};
            rd_class    = rom_in_range ? RC_ROM : RC_FILL;
        end else if (in_ram_win) begin
            rd_class = ram_ok ? RC_RAM : RC_FILL;
        end
    end

endmodule

// File: rtl/mapper_access_fsm.sv
module mapper_access_fsm #(
    parameter int DW     = 8,
    parameter int ROM_AW = 23,
    parameter int RAM_AW = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic              ram_win_wr,
    input  cart_mapper_pkg::rd_class_t rd_class,
    input  logic              ram_ok,
    input  logic [ROM_AW-1:0] rom_addr_nx,
    input  logic [RAM_AW-1:0] ram_addr_nx,
    input  logic [DW-1:0]     cpu_wdata,
    input  logic [DW-1:0]     rom_rdata,
    input  logic [DW-1:0]     ram_rdata,
    output logic [ROM_AW-1:0] rom_addr,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_we,
    output logic [DW-1:0]     ram_wdata,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data
);
    import cart_mapper_pkg::*;

    acc_state_t state, state_nx;

    always_comb begin
        state_nx = ACC_IDLE;
        if (cpu_wr) begin
            state_nx = (ram_win_wr && ram_ok) ? ACC_RAMWR : ACC_IDLE;
        end else if (cpu_rd) begin
            unique case (rd_class)
                RC_ROM:  state_nx = ACC_ROM;
                RC_RAM:  state_nx = ACC_RAM;
                default: state_nx = ACC_FILL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ACC_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rom_addr  <= '0;
            ram_addr  <= '0;
            ram_wdata <= '0;
        end else begin
            if (cpu_rd && !cpu_wr) begin
                rom_addr <= rom_addr_nx;
            end
            if (cpu_rd || cpu_wr) begin
                ram_addr <= ram_addr_nx;
            end
            if (cpu_wr) begin
                ram_wdata <= cpu_wdata;
            end
        end
    end

    always_comb begin
        ram_we   = 1'b0;
        rd_valid = 1'b0;
        rd_data  = FILL_BYTE;
        unique case (state)
            ACC_ROM: begin
                rd_valid = 1'b1;
                rd_data  = rom_rdata;
            end
            ACC_RAM: begin
                rd_valid = 1'b1;
                rd_data  = ram_rdata;
            end
            ACC_FILL:  rd_valid = 1'b1;
            ACC_RAMWR: ram_we = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/cart_mapper.sv
module cart_mapper #(
    parameter int DW         = 8,
    parameter int ROM_BANK_W = 9,
    parameter int RAM_BANK_W = 4,
    parameter int ROM_WIN_W  = 14,
    parameter int RAM_WIN_W  = 13,
    parameter int SZ_W       = $clog2(ROM_BANK_W + 1),
    parameter int ROM_AW     = ROM_BANK_W + ROM_WIN_W,
    parameter int RAM_AW     = RAM_BANK_W + RAM_WIN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [DW-1:0]     cpu_wdata,
    input  logic [SZ_W-1:0]   rom_size_code,
    input  logic [RAM_BANK_W:0] ram_banks,
    input  logic              ram_present,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [DW-1:0]     rom_rdata,
    output logic [RAM_AW-1:0] ram_addr,
    input  logic [DW-1:0]     ram_rdata,
    output logic              ram_we,
    output logic [DW-1:0]     ram_wdata,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data
);
    import cart_mapper_pkg::*;

    logic [ROM_BANK_W-1:0] rom_bank;
    logic [RAM_BANK_W-1:0] ram_bank;
    logic                  ram_en;
    rd_class_t             rd_class;
    logic                  ram_ok;
    logic [ROM_AW-1:0]     rom_addr_nx;
    logic [RAM_AW-1:0]     ram_addr_nx;
    logic                  ram_win_wr;

    assign ram_win_wr = (cpu_addr[15:13] == RAM_WIN_TAG);

    mapper_bank_regs #(
        .DW(DW), .ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cpu_wr),
        .reg_sel  (cpu_addr[15:12]),
        .wdata    (cpu_wdata),
        .rom_bank (rom_bank),
        .ram_bank (ram_bank),
        .ram_en   (ram_en)
    );

    mapper_xlate #(
        .ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W),
        .ROM_WIN_W(ROM_WIN_W), .RAM_WIN_W(RAM_WIN_W), .SZ_W(SZ_W),
        .ROM_AW(ROM_AW), .RAM_AW(RAM_AW)
    ) u_xlate (
        .cpu_addr      (cpu_addr),
        .rom_bank      (rom_bank),
        .ram_bank      (ram_bank),
        .ram_en        (ram_en),
        .rom_size_code (rom_size_code),
        .ram_banks     (ram_banks),
        .ram_present   (ram_present),
        .rd_class      (rd_class),
        .ram_ok        (ram_ok),
        .rom_addr_nx   (rom_addr_nx),
        .ram_addr_nx   (ram_addr_nx)
    );

    mapper_access_fsm #(
        .DW(DW), .ROM_AW(ROM_AW), .RAM_AW(RAM_AW)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_rd      (cpu_rd),
        .cpu_wr      (cpu_wr),
        .ram_win_wr  (ram_win_wr),
        .rd_class    (rd_class),
        .ram_ok      (ram_ok),
        .rom_addr_nx (rom_addr_nx),
        .ram_addr_nx (ram_addr_nx),
        .cpu_wdata   (cpu_wdata),
        .rom_rdata   (rom_rdata),
        .ram_rdata   (ram_rdata),
        .rom_addr    (rom_addr),
        .ram_addr    (ram_addr),
        .ram_we      (ram_we),
        .ram_wdata   (ram_wdata),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data)
    );

endmodule

// File: rtl/cart_mapper_checks.sv
module cart_mapper_checks #(
    parameter int DW        = 8,
    parameter int ROM_WIN_W = 14,
    parameter int ROM_AW    = 23
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       cpu_addr,
    input logic              cpu_wr,
    input logic              cpu_rd,
    input logic [DW-1:0]     cpu_wdata,
    input logic              ram_present,
    input logic [ROM_AW-1:0] rom_addr,
    input logic              ram_we,
    input logic [DW-1:0]     ram_wdata,
    input logic              rd_valid,
    input logic [DW-1:0]     rd_data
);

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_rd && cpu_wr)); // R11

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rd && !cpu_wr |=> rd_valid); // R11

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd |=> !rd_valid); // R11

    AST_HOLE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rd && (cpu_addr[15:13] == 3'b100 || cpu_addr[15:14] == 2'b11)
        |=> rd_data == 8'hFF); // R11

    AST_FIXED_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rd && cpu_addr[15:14] == 2'b00
        |=> rom_addr == ROM_AW'($past(cpu_addr[ROM_WIN_W-1:0]))); // R6

    AST_RAM_ABSENT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rd && cpu_addr[15:13] == 3'b101 && !ram_present
        |=> rd_data == 8'hFF); // R9

    AST_WE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_wr && cpu_addr[15:13] == 3'b101 && ram_present) |=> !ram_we); // R10

    AST_WE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr |=> (!ram_we || ram_wdata == $past(cpu_wdata))); // R10

endmodule

bind cart_mapper cart_mapper_checks #(
    .DW(DW), .ROM_WIN_W(ROM_WIN_W), .ROM_AW(ROM_AW)
) u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_addr    (cpu_addr),
    .cpu_wr      (cpu_wr),
    .cpu_rd      (cpu_rd),
    .cpu_wdata   (cpu_wdata),
    .ram_present (ram_present),
    .rom_addr    (rom_addr),
    .ram_we      (ram_we),
    .ram_wdata   (ram_wdata),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data)
);

// File: tb/tb_cart_mapper.sv
module tb_cart_mapper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [3:0]  rom_size_code = 4'd8;
    logic [4:0]  ram_banks = 5'd16;
    logic        ram_present = 1'b1;
    logic [22:0] rom_addr;
    logic [7:0]  rom_rdata;
    logic [16:0] ram_addr;
    logic [7:0]  ram_rdata;
    logic        ram_we;
    logic [7:0]  ram_wdata;
    logic        rd_valid;
    logic [7:0]  rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model of the bank state and RAM contents
    logic [8:0] m_rom = 9'd1;
    logic [3:0] m_ram = 4'd0;
    logic       m_en  = 1'b0;
    bit [7:0]   exp_mem [int];
    bit [7:0]   ram_mem [int];
    int         mem_gen = 0;

    always #5 clk = ~clk;

    cart_mapper dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .rom_size_code(rom_size_code),
        .ram_banks(ram_banks), .ram_present(ram_present), .rom_addr(rom_addr),
        .rom_rdata(rom_rdata), .ram_addr(ram_addr), .ram_rdata(ram_rdata),
        .ram_we(ram_we), .ram_wdata(ram_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data)
    );

    function automatic logic [7:0] rom_byte(input logic [22:0] a);
        return a[7:0] ^ a[15:8] ^ {1'b0, a[22:16]} ^ 8'h5A;
    endfunction

    assign rom_rdata = rom_byte(rom_addr);

    always @(posedge clk) begin
        if (ram_we) begin
            ram_mem[int'(ram_addr)] = ram_wdata;
            mem_gen++;
        end
    end

    always @(ram_addr, mem_gen) begin
        ram_rdata = ram_mem.exists(int'(ram_addr)) ? ram_mem[int'(ram_addr)] : 8'h00;
    end

    function automatic bit ram_allowed();
        return ram_present && m_en && ({1'b0, m_ram} < ram_banks);
    endfunction

    function automatic logic [7:0] exp_read(input logic [15:0] a);
        int key;
        if (a[15:14] == 2'b00) return rom_byte({9'd0, a[13:0]});
        if (a[15:14] == 2'b01) begin
            if ((m_rom >> (rom_size_code + 1)) != 0) return 8'hFF;
            return rom_byte({m_rom, a[13:0]});
        end
        if (a[15:13] == 3'b101) begin
            if (!ram_allowed()) return 8'hFF;
            key = int'({m_ram, a[12:0]});
            return exp_mem.exists(key) ? exp_mem[key] : 8'h00;
        end
        return 8'hFF;
    endfunction

    task automatic check8(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        if (a[15:13] == 3'b101 && ram_allowed())
            exp_mem[int'({m_ram, a[12:0]})] = d;
        unique case (a[15:12])
            4'h0, 4'h1: m_en = (d == 8'h0A);
            4'h2:       m_rom[7:0] = d;
            4'h3:       m_rom[8] = d[0];
            4'h4, 4'h5: m_ram = d[3:0];
            default: ;
        endcase
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic do_read(input string tag, input logic [15:0] a);
        logic [7:0] e;
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        e = exp_read(a);
        @(negedge clk);
        cpu_rd = 1'b0;
        checks++;
        if (rd_valid !== 1'b1) begin
            errors++;
            $display("FAIL %s valid actual=%b expected=1", tag, rd_valid);
        end
        check8(tag, rd_data, e);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] a;
        int r;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        checks++;
        if (rd_valid !== 1'b0 || ram_we !== 1'b0) begin
            errors++;
            $display("FAIL R1 idle actual=%b%b expected=00", rd_valid, ram_we);
        end
        do_read("R1", 16'h4123);
        do_read("R1", 16'hA000);
        do_read("R6", 16'h3FFF);
        do_read("R6", 16'h0000);

        // R2 exact key
        do_write(16'h1FFF, 8'h0A);
        do_write(16'hA005, 8'h3C);
        do_read("R2", 16'hA005);
        do_write(16'h0000, 8'h1A);
        do_read("R2", 16'hA005);
        do_write(16'h0100, 8'h8A);
        do_read("R2", 16'hA005);
        do_write(16'h0000, 8'h0A);
        do_read("R2", 16'hA005);

        // R3 / R4 split bank number
        do_write(16'h2000, 8'hFF);
        do_write(16'h3000, 8'h01);
        do_read("R4", 16'h7FFF);
        do_write(16'h2FFF, 8'h00);
        do_read("R3", 16'h4000);
        do_write(16'h3FFF, 8'hFE);
        do_read("R4", 16'h5555);
        do_read("R7", 16'h4001);
        do_write(16'h2000, 8'h2A);
        do_read("R7", 16'h6ABC);

        // R5 RAM bank uses low nibble
        do_write(16'h4000, 8'h4F);
        do_write(16'hBFFF, 8'h99);
        do_write(16'h5FFF, 8'h0F);
        do_read("R5", 16'hBFFF);
        do_write(16'h4000, 8'h00);
        do_read("R5", 16'hBFFF);

        // R8 ROM bound
        rom_size_code = 4'd2;
        do_write(16'h2000, 8'h08);
        do_read("R8", 16'h4000);
        do_write(16'h2000, 8'h07);
        do_read("R8", 16'h7FFF);
        do_write(16'h3000, 8'h01);
        do_read("R8", 16'h4444);
        rom_size_code = 4'd8;
        do_read("R8", 16'h4444);

        // R9 / R10 RAM bounds and dropped writes
        ram_banks = 5'd4;
        do_write(16'h4000, 8'h05);
        do_write(16'hA010, 8'h77);
        do_read("R9", 16'hA010);
        do_write(16'h4000, 8'h03);
        do_write(16'hA010, 8'h11);
        do_read("R10", 16'hA010);
        do_write(16'h0000, 8'h00);
        do_write(16'hA010, 8'h22);
        do_write(16'h0000, 8'h0A);
        do_read("R10", 16'hA010);
        ram_present = 1'b0;
        do_read("R9", 16'hA010);
        ram_present = 1'b1;
        ram_banks = 5'd16;

        // R11 / R12 holes and ignored writes
        do_read("R11", 16'h8000);
        do_read("R11", 16'hC123);
        do_write(16'h6000, 8'h00);
        do_write(16'h7FFF, 8'h0F);
        do_write(16'h9000, 8'h00);
        do_write(16'hC000, 8'h00);
        do_write(16'hE000, 8'h00);
        do_read("R12", 16'h4ABC);
        do_read("R12", 16'hA010);

        // constrained random mix
        for (int n = 0; n < 4000; n++) begin
            r = $urandom % 16;
            a = 16'($urandom);
            unique case (r)
                0: begin
                    rom_size_code = 4'($urandom % 9);
                    ram_banks = 5'($urandom % 17);
                    ram_present = ($urandom % 4) != 0;
                end
                1: do_write({3'b000, a[12:0]}, ($urandom % 2) ? 8'h0A : 8'($urandom));
                2: do_write({4'h2, a[11:0]}, 8'($urandom));
                3: do_write({4'h3, a[11:0]}, 8'($urandom));
                4: do_write({3'b010, a[12:0]}, 8'($urandom));
                5, 6: do_write({3'b101, a[12:0]}, 8'($urandom));
                7: do_write(a[15] ? {2'b11, a[13:0]} : {2'b01, 1'b1, a[12:0]}, 8'($urandom));
                8: do_read("R6", {2'b00, a[13:0]});
                9, 10, 11: begin
                    if ((m_rom >> (rom_size_code + 1)) != 0)
                        do_read("R8", {2'b01, a[13:0]});
                    else
                        do_read("R7", {2'b01, a[13:0]});
                end
                12, 13, 14: do_read("R9", {3'b101, a[12:0]});
                default: do_read("R11", a[14] ? {2'b11, a[13:0]} : {3'b100, a[12:0]});
            endcase
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule